// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

This block gives a host processor a small window of 32-bit registers through which it reaches the paged internal register space of an Ethernet switch core. Each switch register is addressed by an 8-bit page and an 8-bit offset within that page. Before it may issue a command, the host has to obtain an access grant. It raises a request bit and polls until the grant bit appears.

With the grant held, the host loads the two write-data words if the access is a write. It then writes one command word that carries the page, the offset, the direction and a go flag. The bridge drives a simple request/acknowledge port towards the switch and keeps the go flag set as a busy indication until the switch acknowledges. Read results come back as a 64-bit value split into a high word and a low word. Narrow switch registers use only the low word. A 48-bit value also uses the lower half of the high word.

The bridge also holds a reset control line for the switch, reports the switch's initialization-done status, and latches single-cycle interrupt pulses from the switch until software clears them.

Top module: `swreg_bridge`

## Requirements
- R1: After reset, every host-visible register reads zero, except the init-done bit at bit 6 of the control register (offset 0x40), which follows its input. The grant is low and no switch transfer is pending.
- R2: Writing bit 3 of the control register (0x40) sets the access request, which reads back at bit 3. The grant at bit 4 reads 0 after GNT_DLY-1 clock edges and 1 after GNT_DLY clock edges, counted from the edge that stored the request.
- R3: After the request bit is cleared, the grant is low after at most two clock edges.
- R4: A command write to offset 0x2C with bit 0 (go) set, made while the grant is held and no transfer is pending, raises sw_req at the next edge. sw_page carries bits 31:24, sw_reg carries bits 23:16, and sw_we carries bit 1 (1 = write). Bit 0 of 0x2C reads 1 while the transfer is pending.
- R5: sw_req and its address fields stay unchanged until the cycle in which sw_ack is high. In the following cycle sw_req is low and bit 0 of 0x2C reads 0.
- R6: A write transfer presents sw_wdata = {high word at 0x30, low word at 0x34}, captured when the command is accepted. Later host writes to those words do not alter an ongoing transfer.
- R7: A read transfer captures sw_rdata in the acknowledge cycle and returns bits 63:32 at 0x38 and bits 31:0 at 0x3C. A write transfer leaves both words unchanged.
- R8: A command with go set that is written while the grant is low starts no transfer.
- R9: A command with go set that is written while a transfer is pending is ignored: the address fields do not change and the switch sees only one acknowledged transfer.
- R10: Bit 2 of every write to 0x2C is stored, whatever the grant or busy state, and drives sw_rst. It reads back at bit 2 of 0x2C.
- R11: Bit 6 of the control register reflects sw_init_done.
- R12: A one-cycle pulse on sw_irq[i] sets bit i of the interrupt register at 0x44. Writing 1 to a bit clears it. A pulse that arrives in the same cycle as the clear leaves the bit set.
- R13: While a transfer is pending, a newly raised request is not granted. The grant follows once the transfer has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | ADDR_W | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data (combinational on hst_addr) |
| sw_req | output | 1 | Switch transfer request, held until acknowledge |
| sw_we | output | 1 | Transfer direction, 1 = write |
| sw_page | output | 8 | Switch register page |
| sw_reg | output | 8 | Register offset within the page |
| sw_wdata | output | 64 | Write data for the switch |
| sw_ack | input | 1 | Switch acknowledge, one cycle |
| sw_rdata | input | 64 | Switch read data, valid with sw_ack |
| sw_rst | output | 1 | Reset control to the switch |
| sw_init_done | input | 1 | Switch initialization finished |
| sw_irq | input | IRQ_W | Interrupt pulses from the switch |

## Verification
Directed sequences cover four cases: a command with no grant, a command issued while another is busy, a re-request raised during a slow transfer, and an interrupt pulse that collides with a clear. They separate gating faults from faults in the sequencing itself. Grant latency is measured at the exact edges around GNT_DLY, so an off-by-one in the counter shows up. A seeded random run then mixes reads and writes to random pages and offsets, with random switch latency and random 64-bit data. Each read-back is compared with a shadow copy of earlier writes, which exposes swapped data halves, dropped or duplicated transfers and wrong address fields.

// File: rtl/swb_pkg.sv
package swb_pkg;
   // host window byte offsets
   localparam logic [7:0] OFF_CMD = 8'h2C;
   localparam logic [7:0] OFF_WDH = 8'h30;
   localparam logic [7:0] OFF_WDL = 8'h34;
   localparam logic [7:0] OFF_RDH = 8'h38;
   localparam logic [7:0] OFF_RDL = 8'h3C;
   localparam logic [7:0] OFF_CTL = 8'h40;
   localparam logic [7:0] OFF_IRQ = 8'h44;

   // command word bit positions
   localparam int CMD_GO   = 0;
   localparam int CMD_WE   = 1;
   localparam int CMD_RST  = 2;
   localparam int CMD_REGL = 16;
   localparam int CMD_PGL  = 24;

   // control word bit positions
   localparam int CTL_REQ  = 3;
   localparam int CTL_GNT  = 4;
   localparam int CTL_INIT = 6;

   localparam int HOST_W = 32;
   localparam int PG_W   = 8;
   localparam int RG_W   = 8;
   localparam int XFER_W = 2 * HOST_W;

   typedef struct packed {
      logic [PG_W-1:0] page;
      logic [RG_W-1:0] regi;
      logic            we;
   } swb_cmd_t;
endpackage

// File: rtl/swb_grant.sv
module swb_grant #(
   parameter int GNT_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic busy,
   output logic gnt
);
   localparam int CNT_W = $clog2(GNT_DLY + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GNT_DLY - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         gnt <= 1'b0;
      end else if (!req) begin
         cnt <= '0;
         gnt <= 1'b0;
      end else if (!gnt) begin
         if (cnt >= LAST) begin
            if (!busy) gnt <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/swb_seq.sv
module swb_seq
   import swb_pkg::*;
#(
   parameter bit LATCH_WDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              cmd_go,
   input  swb_cmd_t          cmd_in,
   input  logic              gnt,
   input  logic [XFER_W-1:0] wdata_in,
   input  logic              sw_ack,
   input  logic [XFER_W-1:0] sw_rdata,
   output logic              busy,
   output swb_cmd_t          cmd_q,
   output logic [XFER_W-1:0] sw_wdata,
   output logic [XFER_W-1:0] rd_q
);
   logic accept;
   assign accept = cmd_wr && cmd_go && gnt && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cmd_q <= '0;
         rd_q  <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         cmd_q <= cmd_in;
      end else if (busy && sw_ack) begin
         busy <= 1'b0;
         if (!cmd_q.we) rd_q <= sw_rdata;
      end
   end

   generate
      if (LATCH_WDATA) begin : g_latch
         logic [XFER_W-1:0] wd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      wd_q <= '0;
            else if (accept) wd_q <= wdata_in;
         end
         assign sw_wdata = wd_q;
      end else begin : g_pass
         assign sw_wdata = wdata_in;
      end
   endgenerate
endmodule

// File: rtl/swb_irq.sv
module swb_irq #(
   parameter int IRQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] pulse,
   input  logic             clr_wr,
   input  logic [IRQ_W-1:0] clr_mask,
   output logic [IRQ_W-1:0] irq_q
);
   generate
      for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)                       irq_q[i] <= 1'b0;
            else if (pulse[i])                irq_q[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])   irq_q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
   import swb_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int GNT_DLY     = 4,
   parameter int IRQ_W       = 8,
   parameter bit LATCH_WDATA = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hst_we,
   input  logic [ADDR_W-1:0]    hst_addr,
   input  logic [HOST_W-1:0]    hst_wdata,
   output logic [HOST_W-1:0]    hst_rdata,
   output logic                 sw_req,
   output logic                 sw_we,
   output logic [PG_W-1:0]      sw_page,
   output logic [RG_W-1:0]      sw_reg,
   output logic [XFER_W-1:0]    sw_wdata,
   input  logic                 sw_ack,
   input  logic [XFER_W-1:0]    sw_rdata,
   output logic                 sw_rst,
   input  logic                 sw_init_done,
   input  logic [IRQ_W-1:0]     sw_irq
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_WDH = ADDR_W'(OFF_WDH);
   localparam logic [ADDR_W-1:0] A_WDL = ADDR_W'(OFF_WDL);
   localparam logic [ADDR_W-1:0] A_RDH = ADDR_W'(OFF_RDH);
   localparam logic [ADDR_W-1:0] A_RDL = ADDR_W'(OFF_RDL);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);
   localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(OFF_IRQ);

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("swreg_bridge: ADDR_W must cover offset 0x44");
      end
      if (GNT_DLY < 1) begin : g_bad_dly
         $error("swreg_bridge: GNT_DLY must be at least 1");
      end
      if (IRQ_W < 1 || IRQ_W > HOST_W) begin : g_bad_irq
         $error("swreg_bridge: IRQ_W must be 1..32");
      end
   endgenerate

   logic                req_q;
   logic                rst_q;
   logic [HOST_W-1:0]   wd_hi, wd_lo;
   logic                gnt;
   logic                busy;
   swb_cmd_t            cmd_in, cmd_q;
   logic [XFER_W-1:0]   rd_q;
   logic [IRQ_W-1:0]    irq_q;
   logic                wr_cmd, wr_ctl, wr_irq;

   assign wr_cmd = hst_we && (hst_addr == A_CMD);
   assign wr_ctl = hst_we && (hst_addr == A_CTL);
   assign wr_irq = hst_we && (hst_addr == A_IRQ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         rst_q <= 1'b0;
         wd_hi <= '0;
         wd_lo <= '0;
      end else if (hst_we) begin
         if (wr_ctl)             req_q <= hst_wdata[CTL_REQ];
         if (wr_cmd)             rst_q <= hst_wdata[CMD_RST];
         if (hst_addr == A_WDH)  wd_hi <= hst_wdata;
         if (hst_addr == A_WDL)  wd_lo <= hst_wdata;
      end
   end

   assign cmd_in.page = hst_wdata[CMD_PGL +: PG_W];
   assign cmd_in.regi = hst_wdata[CMD_REGL +: RG_W];
   assign cmd_in.we   = hst_wdata[CMD_WE];

   swb_grant #(.GNT_DLY(GNT_DLY)) i_grant (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_q),
      .busy  (busy),
      .gnt   (gnt)
   );

   swb_seq #(.LATCH_WDATA(LATCH_WDATA)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (wr_cmd),
      .cmd_go   (hst_wdata[CMD_GO]),
      .cmd_in   (cmd_in),
      .gnt      (gnt),
      .wdata_in ({wd_hi, wd_lo}),
      .sw_ack   (sw_ack),
      .sw_rdata (sw_rdata),
      .busy     (busy),
      .cmd_q    (cmd_q),
      .sw_wdata (sw_wdata),
      .rd_q     (rd_q)
   );

   swb_irq #(.IRQ_W(IRQ_W)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse    (sw_irq),
      .clr_wr   (wr_irq),
      .clr_mask (hst_wdata[IRQ_W-1:0]),
      .irq_q    (irq_q)
   );

   assign sw_req  = busy;
   assign sw_we   = cmd_q.we;
   assign sw_page = cmd_q.page;
   assign sw_reg  = cmd_q.regi;
   assign sw_rst  = rst_q;

   always_comb begin
      hst_rdata = '0;
      case (hst_addr)
         A_CMD: hst_rdata = {cmd_q.page, cmd_q.regi, 13'b0, rst_q, cmd_q.we, busy};
         A_WDH: hst_rdata = wd_hi;
         A_WDL: hst_rdata = wd_lo;
         A_RDH: hst_rdata = rd_q[XFER_W-1:HOST_W];
         A_RDL: hst_rdata = rd_q[HOST_W-1:0];
         A_CTL: begin
            hst_rdata[CTL_REQ]  = req_q;
            hst_rdata[CTL_GNT]  = gnt;
            hst_rdata[CTL_INIT] = sw_init_done;
         end
         A_IRQ: hst_rdata = HOST_W'(irq_q);
         default: hst_rdata = '0;
      endcase
   end
endmodule

// File: rtl/swb_chk.sv
module swb_chk #(
   parameter int IRQ_W       = 8,
   parameter bit LATCH_WDATA = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_req,
   input logic             sw_ack,
   input logic             sw_we,
   input logic [7:0]       sw_page,
   input logic [7:0]       sw_reg,
   input logic [63:0]      sw_wdata,
   input logic             gnt,
   input logic             req_q,
   input logic [IRQ_W-1:0] sw_irq,
   input logic [IRQ_W-1:0] irq_q
);
   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && !sw_ack |=> sw_req);

   // R5
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && sw_ack |=> !sw_req);

   // R6
   fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && !sw_ack |=> $stable(sw_page) && $stable(sw_reg) && $stable(sw_we)
                            && (!LATCH_WDATA || $stable(sw_wdata)));

   // R3
   gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_q |=> !gnt);

   // R13
   gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt && sw_req |=> !gnt);

   // R8
   start_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt && !sw_req |=> !sw_req);

   // R12
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sw_irq) |=> ((irq_q & $past(sw_irq)) == $past(sw_irq)));
endmodule

bind swreg_bridge swb_chk #(.IRQ_W(IRQ_W), .LATCH_WDATA(LATCH_WDATA)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sw_req   (sw_req),
   .sw_ack   (sw_ack),
   .sw_we    (sw_we),
   .sw_page  (sw_page),
   .sw_reg   (sw_reg),
   .sw_wdata (sw_wdata),
   .gnt      (gnt),
   .req_q    (req_q),
   .sw_irq   (sw_irq),
   .irq_q    (irq_q)
);

// File: tb/test_swreg_bridge.sv
`timescale 1ns/1ps
module test_swreg_bridge;
   localparam int GNT_DLY = 4;
   localparam int IRQ_W   = 8;
   localparam logic [7:0] T_CMD = 8'h2C, T_WDH = 8'h30, T_WDL = 8'h34,
                          T_RDH = 8'h38, T_RDL = 8'h3C, T_CTL = 8'h40, T_IRQ = 8'h44;

   logic clk = 0, rst_n = 0;
   logic hst_we = 0;
   logic [7:0] hst_addr = '0;
   logic [31:0] hst_wdata = '0, hst_rdata;
   logic sw_req, sw_we, sw_rst;
   logic [7:0] sw_page, sw_reg;
   logic [63:0] sw_wdata, sw_rdata;
   logic sw_ack;
   logic sw_init_done = 0;
   logic [IRQ_W-1:0] sw_irq = '0;

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   swreg_bridge #(.GNT_DLY(GNT_DLY), .IRQ_W(IRQ_W)) i_swreg_bridge (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .sw_req(sw_req),
      .sw_we(sw_we), .sw_page(sw_page), .sw_reg(sw_reg), .sw_wdata(sw_wdata),
      .sw_ack(sw_ack), .sw_rdata(sw_rdata), .sw_rst(sw_rst),
      .sw_init_done(sw_init_done), .sw_irq(sw_irq));

   // switch model: small register array with programmable acknowledge latency
   logic [63:0] mem [64];
   logic [63:0] shadow [64];
   int   lat = 0;
   int   lcnt = 0;
   int   ack_cnt = 0;
   logic [7:0]  log_page, log_reg;
   logic        log_we;
   logic [63:0] log_wdata;

   function automatic int idx(input logic [7:0] pg, input logic [7:0] rg);
      return int'({pg[1:0], rg[3:0]});
   endfunction

   assign sw_rdata = mem[idx(sw_page, sw_reg)];

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i] = '0;
         shadow[i] = '0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         sw_ack <= 1'b0;
         lcnt   <= 0;
      end else if (sw_req && !sw_ack) begin
         if (lcnt >= lat) begin
            sw_ack <= 1'b1;
            lcnt   <= 0;
         end else lcnt <= lcnt + 1;
      end else sw_ack <= 1'b0;
      if (rst_n && sw_req && sw_ack) begin
         if (sw_we) mem[idx(sw_page, sw_reg)] <= sw_wdata;
         ack_cnt   <= ack_cnt + 1;
         log_page  <= sw_page;
         log_reg   <= sw_reg;
         log_we    <= sw_we;
         log_wdata <= sw_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      hst_we = 1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_we = 0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [31:0] d);
      hst_we = 0; hst_addr = a;
      #1 d = hst_rdata;
   endtask

   function automatic logic [31:0] cmdw(input logic [7:0] pg, input logic [7:0] rg,
                                        input bit rst, input bit we, input bit go);
      return {pg, rg, 13'b0, rst, we, go};
   endfunction

   task automatic get_grant(output bit ok);
      logic [31:0] v;
      ok = 0;
      hwrite(T_CTL, 32'h8);
      for (int i = 0; i < 200; i++) begin
         hread(T_CTL, v);
         if (v[4]) begin ok = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 400; i++) begin
         hread(T_CMD, v);
         if (!v[0]) break;
         @(negedge clk);
      end
   endtask

   task automatic access(input bit we, input logic [7:0] pg, input logic [7:0] rg,
                         input logic [63:0] d, output logic [63:0] rd);
      bit ok;
      logic [31:0] h, l;
      get_grant(ok);
      check(ok, "R2 grant obtained", 64'(ok), 64'd1);
      if (we) begin
         hwrite(T_WDH, d[63:32]);
         hwrite(T_WDL, d[31:0]);
      end
      hwrite(T_CMD, cmdw(pg, rg, 0, we, 1));
      wait_idle();
      hread(T_RDH, h);
      hread(T_RDL, l);
      rd = {h, l};
      hwrite(T_CTL, 32'h0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] v, v2;
      logic [63:0] rd;
      bit ok;
      int acks0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      hread(T_CMD, v); check(v == 0, "R1 cmd reg", 64'(v), 0);
      hread(T_CTL, v); check(v == 0, "R1 ctl reg", 64'(v), 0);
      hread(T_IRQ, v); check(v == 0, "R1 irq reg", 64'(v), 0);
      hread(T_RDL, v); check(v == 0, "R1 read low", 64'(v), 0);
      check(sw_req == 0 && sw_rst == 0, "R1 switch port idle", 64'({sw_req, sw_rst}), 0);

      // R11 init done
      sw_init_done = 1;
      hread(T_CTL, v); check(v[6] == 1, "R11 init done", 64'(v[6]), 1);

      // R8 command without grant
      acks0 = ack_cnt;
      hwrite(T_CMD, cmdw(8'h05, 8'h01, 0, 0, 1));
      hread(T_CMD, v);
      check(sw_req == 0 && v[0] == 0, "R8 no start without grant", 64'({sw_req, v[0]}), 0);
      repeat (4) @(negedge clk);
      check(ack_cnt == acks0, "R8 no transfer", 64'(ack_cnt), 64'(acks0));

      // R10 reset control
      hwrite(T_CMD, 32'h4);
      hread(T_CMD, v);
      check(sw_rst == 1 && v[2] == 1, "R10 reset bit set", 64'({sw_rst, v[2]}), 64'b11);
      hwrite(T_CMD, 32'h0);
      check(sw_rst == 0, "R10 reset bit cleared", 64'(sw_rst), 0);

      // R2 grant latency
      hwrite(T_CTL, 32'h8);
      repeat (GNT_DLY - 1) @(negedge clk);
      hread(T_CTL, v);
      check(v[3] == 1 && v[4] == 0, "R2 grant not yet", 64'(v[4:3]), 64'b01);
      @(negedge clk);
      hread(T_CTL, v);
      check(v[4] == 1, "R2 grant after delay", 64'(v[4]), 1);

      // R4 R6 R9 R5 slow write transfer
      lat = 10;
      hwrite(T_WDH, 32'hA5A5_0001);
      hwrite(T_WDL, 32'h1234_5678);
      hwrite(T_CMD, cmdw(8'h12, 8'h34, 0, 1, 1));
      hread(T_CMD, v);
      check(sw_req && sw_page == 8'h12 && sw_reg == 8'h34 && sw_we && v[0],
            "R4 command fields", {sw_req, sw_we, v[0], sw_page, sw_reg}, {3'b111, 16'h1234});
      check(sw_wdata == 64'hA5A5_0001_1234_5678, "R6 write data", sw_wdata, 64'hA5A5_0001_1234_5678);
      acks0 = ack_cnt;
      hwrite(T_WDL, 32'hDEAD_BEEF);
      hwrite(T_CMD, cmdw(8'h20, 8'h07, 0, 0, 1));
      check(sw_page == 8'h12 && sw_reg == 8'h34 && sw_we, "R9 busy command ignored",
            {sw_page, sw_reg}, 64'h1234);
      check(sw_wdata == 64'hA5A5_0001_1234_5678, "R6 data held", sw_wdata, 64'hA5A5_0001_1234_5678);
      hread(T_CMD, v);
      check(sw_req && v[0], "R5 held before ack", 64'({sw_req, v[0]}), 64'b11);
      for (int i = 0; i < 100; i++) begin
         if (sw_ack) break;
         @(negedge clk);
      end
      @(negedge clk);
      hread(T_CMD, v);
      check(!sw_req && !v[0], "R5 cleared after ack", 64'({sw_req, v[0]}), 0);
      repeat (3) @(negedge clk);
      check(ack_cnt == acks0 + 1, "R9 single transfer", 64'(ack_cnt), 64'(acks0 + 1));
      check(log_wdata == 64'hA5A5_0001_1234_5678, "R6 switch got data", log_wdata,
            64'hA5A5_0001_1234_5678);
      shadow[idx(8'h12, 8'h34)] = 64'hA5A5_0001_1234_5678;

      // R3 grant drop
      hwrite(T_CTL, 32'h0);
      @(negedge clk);
      hread(T_CTL, v);
      check(v[4] == 0 && v[3] == 0, "R3 grant dropped", 64'(v[4:3]), 0);

      // R7 read back, then a write must not touch read words
      lat = 2;
      access(0, 8'h12, 8'h34, 64'h0, rd);
      check(rd == 64'hA5A5_0001_1234_5678, "R7 read data", rd, 64'hA5A5_0001_1234_5678);
      access(1, 8'h01, 8'h02, 64'h0000_BEEF_CAFE_F00D, rd);
      shadow[idx(8'h01, 8'h02)] = 64'h0000_BEEF_CAFE_F00D;
      check(rd == 64'hA5A5_0001_1234_5678, "R7 write keeps read words", rd,
            64'hA5A5_0001_1234_5678);

      // R13 no grant while a transfer is pending
      lat = 30;
      get_grant(ok);
      hwrite(T_CMD, cmdw(8'h01, 8'h02, 0, 0, 1));
      hwrite(T_CTL, 32'h0);
      hwrite(T_CTL, 32'h8);
      repeat (GNT_DLY + 3) @(negedge clk);
      hread(T_CTL, v); hread(T_CMD, v2);
      check(v[4] == 0 && v2[0] == 1, "R13 grant withheld while busy", 64'({v[4], v2[0]}), 64'b01);
      wait_idle();
      repeat (GNT_DLY + 1) @(negedge clk);
      hread(T_CTL, v);
      check(v[4] == 1, "R13 grant after completion", 64'(v[4]), 1);
      hread(T_RDH, v); hread(T_RDL, v2);
      check({v, v2} == 64'h0000_BEEF_CAFE_F00D, "R7 pending read data", {v, v2},
            64'h0000_BEEF_CAFE_F00D);
      hwrite(T_CTL, 32'h0);

      // R12 interrupt latch
      @(negedge clk);
      sw_irq = 8'h24;
      @(negedge clk);
      sw_irq = 8'h00;
      hread(T_IRQ, v); check(v == 32'h24, "R12 pulses latched", 64'(v), 64'h24);
      hwrite(T_IRQ, 32'h04);
      hread(T_IRQ, v); check(v == 32'h20, "R12 write one clears", 64'(v), 64'h20);
      @(negedge clk);
      hst_we = 1; hst_addr = T_IRQ; hst_wdata = 32'h20; sw_irq = 8'h20;
      @(negedge clk);
      hst_we = 0; sw_irq = 8'h00;
      hread(T_IRQ, v); check(v == 32'h20, "R12 set wins over clear", 64'(v), 64'h20);
      hwrite(T_IRQ, 32'hFF);
      hread(T_IRQ, v); check(v == 0, "R12 all cleared", 64'(v), 0);

      // random mix of reads and writes
      for (int n = 0; n < 80; n++) begin
         logic [7:0]  pg, rg;
         logic [63:0] d;
         bit          we;
         lat = int'($urandom % 5);
         pg  = 8'($urandom);
         rg  = 8'($urandom);
         d   = {$urandom, $urandom};
         we  = bit'($urandom % 2);
         access(we, pg, rg, d, rd);
         check(log_page == pg && log_reg == rg && log_we == we, "R4 random address",
               {log_we, log_page, log_reg}, {we, pg, rg});
         if (we) begin
            check(log_wdata == d, "R6 random write data", log_wdata, d);
            shadow[idx(pg, rg)] = d;
         end else begin
            check(rd == shadow[idx(pg, rg)], "R7 random read data", rd, shadow[idx(pg, rg)]);
         end
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule